// File: doc/BRIEF.md
# Fence and Interrupt Status Unit

This unit watches a command stream for completed fences and turns them, together with a forward-progress pulse from the command consumer, into interrupt status flags. Each completed fence carries a 32-bit value. That value is stored in a readable last-fence register. The value is also compared against a programmable goal. A host reaches the status, mask, goal, last-fence and capability words through a simple register bus. It clears status flags by writing ones to them.

A single level interrupt output stays high while any status flag is set and its mask bit is also set. Three sources feed the status word:
- bit 0: any fence completed
- bit 1: the command queue made progress
- bit 2: a fence value exactly matched the goal, while bit 2 of the mask was set

Register offsets are 0 for status, 1 for mask, 2 for goal, 3 for last fence and 4 for capability. Writes take effect at the next clock edge. Reads are combinational.

Top module: `fence_irq_unit`

## Requirements
- R1: After reset the status, mask, goal and last-fence registers all read zero and the interrupt output is low.
- R2: A fence event copies its 32-bit value into the last-fence register (offset 3) at the next clock edge; host writes to offset 3 have no effect.
- R3: Every fence event sets status bit 0, whatever the fence value and the mask.
- R4: A progress pulse sets status bit 1.
- R5: Status bit 2 is set by a fence event only when the fence value equals the goal register (offset 2), as held before that edge, and mask bit 2 is 1.
- R6: A host write to offset 0 clears each status bit whose write-data bit is 1; bits written with 0 keep their value.
- R7: When an event sets a status bit in the same cycle that a host write clears it, the bit ends up set.
- R8: The interrupt output is high exactly when the bitwise AND of status and the mask register (offset 1, bits 2:0) is nonzero.
- R9: A fence event and a progress pulse in the same cycle both set their status bits in that cycle.
- R10: Offset 4 reads a capability word whose bit 0 is 1 when the mask capability is built in; offsets above 4 read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fence_valid | input | 1 | A fence completed this cycle |
| fence_value | input | DATA_W | Value carried by the completed fence |
| progress_pulse | input | 1 | Command consumer made forward progress |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host register offset |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with its defaults: DATA_W of 32, ADDR_W of 4 and the mask capability present. Full 32-bit fence values let it reach goal near-misses that differ only in high bits. The 4-bit address lets it probe the unused offsets 5 to 15. Directed steps cover set-versus-clear collisions and simultaneous sources. A pseudo-random phase then mixes fences, pulses and writes across every offset, and the design is compared against a behavioural model on every clock.

// File: rtl/fence_irq_pkg.sv
package fence_irq_pkg;

  localparam int NUM_SRC  = 3;
  localparam int SRC_ANY  = 0;
  localparam int SRC_PROG = 1;
  localparam int SRC_GOAL = 2;

  localparam int OFS_STATUS = 0;
  localparam int OFS_MASK   = 1;
  localparam int OFS_GOAL   = 2;
  localparam int OFS_LAST   = 3;
  localparam int OFS_CAPS   = 4;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Write-one-to-clear, then event sets override.
  function automatic src_vec_t status_next(src_vec_t cur, src_vec_t set_v,
                                           src_vec_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  function automatic logic irq_level(src_vec_t st, src_vec_t msk);
    return |(st & msk);
  endfunction

endpackage

// File: rtl/fence_reg_decode.sv
module fence_reg_decode
  import fence_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter bit MASK_EN = 1'b1
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  src_vec_t          status_q,
  input  src_vec_t          mask_q,
  input  logic [DATA_W-1:0] goal_q,
  input  logic [DATA_W-1:0] last_q,
  output logic              wr_status,
  output logic              wr_mask,
  output logic              wr_goal,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic sel_status, sel_mask, sel_goal, sel_last, sel_caps;

  assign sel_status = (bus_addr == ADDR_W'(OFS_STATUS));
  assign sel_mask   = (bus_addr == ADDR_W'(OFS_MASK));
  assign sel_goal   = (bus_addr == ADDR_W'(OFS_GOAL));
  assign sel_last   = (bus_addr == ADDR_W'(OFS_LAST));
  assign sel_caps   = (bus_addr == ADDR_W'(OFS_CAPS));

  assign wr_status = bus_wr & sel_status;
  assign wr_mask   = bus_wr & sel_mask;
  assign wr_goal   = bus_wr & sel_goal;

  always_comb begin
    bus_rdata = '0;
    if (sel_status)    bus_rdata = {{PAD_W{1'b0}}, status_q};
    else if (sel_mask) bus_rdata = {{PAD_W{1'b0}}, mask_q};
    else if (sel_goal) bus_rdata = goal_q;
    else if (sel_last) bus_rdata = last_q;
    else if (sel_caps) bus_rdata = {{(DATA_W-1){1'b0}}, MASK_EN};
  end

endmodule

// File: rtl/fence_track.sv
module fence_track #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fence_valid,
  input  logic [DATA_W-1:0] fence_value,
  input  logic              wr_goal,
  input  logic [DATA_W-1:0] goal_wdata,
  input  logic              goal_enable,
  output logic [DATA_W-1:0] last_q,
  output logic [DATA_W-1:0] goal_q,
  output logic              goal_hit
);

  // Compare against the goal held before this edge.
  assign goal_hit = fence_valid & goal_enable & (fence_value == goal_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      goal_q <= '0;
    end else begin
      if (fence_valid) last_q <= fence_value;
      if (wr_goal)     goal_q <= goal_wdata;
    end
  end

endmodule

// File: rtl/irq_status.sv
module irq_status
  import fence_irq_pkg::*;
#(
  parameter bit MASK_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  logic     wr_status,
  input  src_vec_t clr_data,
  input  logic     wr_mask,
  input  src_vec_t mask_data,
  output src_vec_t status_q,
  output src_vec_t mask_q,
  output logic     irq
);

  src_vec_t clr_vec;
  assign clr_vec = wr_status ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_next(status_q, set_vec, clr_vec);
  end

  generate
    if (MASK_EN) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= mask_data;
      end
    end else begin : g_no_mask
      assign mask_q = '0;
    end
  endgenerate

  assign irq = irq_level(status_q, mask_q);

endmodule

// File: rtl/fence_irq_unit.sv
module fence_irq_unit
  import fence_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter bit MASK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fence_valid,
  input  logic [DATA_W-1:0] fence_value,
  input  logic              progress_pulse,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  // Named internal events, visible to the bound checker.
  logic              wr_status, wr_mask, wr_goal;
  logic              goal_hit;
  src_vec_t          set_vec;
  src_vec_t          status_q, mask_q;
  logic [DATA_W-1:0] goal_q, last_q;

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_ANY]  = fence_valid;
    set_vec[SRC_PROG] = progress_pulse;
    set_vec[SRC_GOAL] = goal_hit;
  end

  fence_reg_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_EN(MASK_EN)) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .goal_q    (goal_q),
    .last_q    (last_q),
    .wr_status (wr_status),
    .wr_mask   (wr_mask),
    .wr_goal   (wr_goal),
    .bus_rdata (bus_rdata)
  );

  fence_track #(.DATA_W(DATA_W)) u_fence (
    .clk         (clk),
    .rst_n       (rst_n),
    .fence_valid (fence_valid),
    .fence_value (fence_value),
    .wr_goal     (wr_goal),
    .goal_wdata  (bus_wdata),
    .goal_enable (mask_q[SRC_GOAL]),
    .last_q      (last_q),
    .goal_q      (goal_q),
    .goal_hit    (goal_hit)
  );

  irq_status #(.MASK_EN(MASK_EN)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .wr_status (wr_status),
    .clr_data  (bus_wdata[NUM_SRC-1:0]),
    .wr_mask   (wr_mask),
    .mask_data (bus_wdata[NUM_SRC-1:0]),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

endmodule

// File: rtl/fence_irq_checks.sv
module fence_irq_checks
  import fence_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fence_valid,
  input logic [DATA_W-1:0] fence_value,
  input logic              progress_pulse,
  input logic              wr_status,
  input logic [DATA_W-1:0] bus_wdata,
  input src_vec_t          status_q,
  input src_vec_t          mask_q,
  input logic [DATA_W-1:0] goal_q,
  input logic [DATA_W-1:0] last_q,
  input logic              irq
);

  p_last_fence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fence_valid |=> (last_q == $past(fence_value)));

  p_any_fence_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fence_valid |=> status_q[SRC_ANY]);

  p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
    progress_pulse |=> status_q[SRC_PROG]);

  p_goal_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[SRC_GOAL]) |->
      $past(fence_valid && mask_q[SRC_GOAL] && (fence_value == goal_q)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && bus_wdata[SRC_PROG] && !progress_pulse) |=> !status_q[SRC_PROG]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && bus_wdata[SRC_ANY] && fence_valid) |=> status_q[SRC_ANY]);

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0));

endmodule

bind fence_irq_unit fence_irq_checks #(.DATA_W(DATA_W)) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .fence_valid    (fence_valid),
  .fence_value    (fence_value),
  .progress_pulse (progress_pulse),
  .wr_status      (wr_status),
  .bus_wdata      (bus_wdata),
  .status_q       (status_q),
  .mask_q         (mask_q),
  .goal_q         (goal_q),
  .last_q         (last_q),
  .irq            (irq)
);

// File: tb/sim_fence_irq_unit.sv
`timescale 1ns/1ps
module sim_fence_irq_unit;

  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fence_valid = 1'b0;
  logic [DW-1:0] fence_value = '0;
  logic          progress_pulse = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state
  int unsigned m_status = 0, m_mask = 0, m_goal = 0, m_last = 0;

  always #10 clk = ~clk;

  fence_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .fence_valid(fence_valid), .fence_value(fence_value),
    .progress_pulse(progress_pulse), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural model, updated on the same edge as the design.
  always @(posedge clk) begin
    int unsigned set_b, clr_b;
    if (!rst_n) begin
      m_status = 0; m_mask = 0; m_goal = 0; m_last = 0;
    end else begin
      set_b = 0;
      if (fence_valid) set_b = set_b | 1;
      if (progress_pulse) set_b = set_b | 2;
      if (fence_valid && fence_value == m_goal && m_mask[2]) set_b = set_b | 4;
      clr_b = (bus_wr && bus_addr == 0) ? (bus_wdata & 7) : 0;
      m_status = (m_status & ~clr_b) | set_b;
      if (bus_wr && bus_addr == 1) m_mask = bus_wdata & 7;
      if (bus_wr && bus_addr == 2) m_goal = bus_wdata;
      if (fence_valid) m_last = fence_value;
    end
  end

  function automatic int unsigned exp_read(int a);
    case (a)
      0: return m_status;
      1: return m_mask;
      2: return m_goal;
      3: return m_last;
      4: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R6";
      1: return "R8";
      2: return "R5";
      3: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8", 32'(irq), ((m_status & m_mask) != 0) ? 1 : 0);
      check(tag_of(int'(bus_addr)), bus_rdata, exp_read(int'(bus_addr)));
    end
  end

  task automatic cyc(bit fv, int unsigned fval, bit prog, bit wr, int a, int unsigned wd);
    @(posedge clk); #1;
    fence_valid = fv; fence_value = fval; progress_pulse = prog;
    bus_wr = wr; bus_addr = AW'(a); bus_wdata = wd;
  endtask

  task automatic rd(int a, int unsigned exp, string req);
    @(posedge clk); #1;
    fence_valid = 0; progress_pulse = 0; bus_wr = 0; bus_addr = AW'(a);
    @(negedge clk); #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic wr(int a, int unsigned d);
    cyc(0, 0, 0, 1, a, d);
  endtask

  initial begin
    int unsigned lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    check("R1", 32'(irq), 0);
    rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1"); rd(3, 0, "R1");
    rd(4, 1, "R10"); rd(7, 0, "R10");

    // R2/R3 fence with mask off
    cyc(1, 32'hA5A5_0001, 0, 0, 0, 0);
    rd(3, 32'hA5A5_0001, "R2");
    rd(0, 1, "R3");
    check("R8", 32'(irq), 0);
    // R2 write to last-fence ignored
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'hA5A5_0001, "R2");
    // R4 progress
    cyc(0, 0, 1, 0, 0, 0);
    rd(0, 3, "R4");
    // R8 mask enables irq
    wr(1, 7);
    rd(1, 7, "R8");
    check("R8", 32'(irq), 1);
    // R6 write-one-to-clear
    wr(0, 1);
    rd(0, 2, "R6");
    wr(0, 0);
    rd(0, 2, "R6");
    // R5 goal gated by mask bit 2
    wr(2, 32'h0000_1234);
    wr(1, 3);
    cyc(1, 32'h0000_1234, 0, 0, 0, 0);
    rd(0, 3, "R5");
    wr(1, 4);
    cyc(1, 32'h8000_1234, 0, 0, 0, 0);
    rd(0, 3, "R5");
    check("R8", 32'(irq), 0);
    cyc(1, 32'h0000_1234, 0, 0, 0, 0);
    rd(0, 7, "R5");
    check("R8", 32'(irq), 1);
    // R7 set wins over clear
    cyc(1, 32'h55, 0, 1, 0, 1);
    rd(0, 7, "R7");
    // R9 simultaneous fence and progress after full clear
    wr(0, 7);
    rd(0, 0, "R6");
    check("R8", 32'(irq), 0);
    cyc(1, 32'h99, 1, 0, 0, 0);
    rd(0, 3, "R9");
    // R10 unused offset writes ignored
    wr(9, 32'hFFFF_FFFF);
    rd(9, 0, "R10");
    rd(1, 4, "R10");

    // Pseudo-random mix, compared every cycle
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[0], lfsr[3] ? 32'h0000_1234 : {28'h0, lfsr[7:4]}, lfsr[1],
          lfsr[2], int'(lfsr[11:8]) % 6, {29'h0, lfsr[14:12]});
    end
    cyc(0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule